// File: doc/BRIEF.md
# Transport Packet FIFO Write Packer

This block sits between a byte-wide transport-stream capture path and a 64-bit receive FIFO. Incoming packet bytes arrive one per accepted cycle over a valid/ready handshake and are gathered eight at a time into FIFO words. The byte order inside a word is set by a mode pin. Once the last byte of a packet has been placed, the block writes one more word to the same FIFO bus. This status word carries two error flags gathered over the packet and the clock-reference sample taken when the packet began.

A byte counter tracks the position within each packet. The packet length is read from the `pkt_len` pin when the first byte arrives. On that first byte the block pulses a request to the counter-sampling logic, takes the returned reference value, and holds it until the status word goes out. If the FIFO reports full when a word is due, the rest of that packet is discarded and a sticky overflow flag is raised. Storage, clock-domain crossing of the reference counter and sync detection are left to neighbouring blocks.

Back-pressure rules: a byte moves only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` drops for exactly one cycle, the cycle in which a status word is being written. The FIFO side has no stall: a word that is due while `fifo_full` is high is lost.

Top module: `tsp_fifo_packer`

## Requirements
- R1: A byte is taken on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 in the single cycle after the last byte of a packet that is not being dropped, and 1 in all other cycles.
- R2: Every eighth byte of a packet completes a word. `fifo_wr_en` is high for one cycle, the cycle after the edge that took that byte.
- R3: When `big_endian` is 0, byte k of a word (k = 0 for the earliest) occupies bits 8k+7:8k.
- R4: When `big_endian` is 1, byte k of a word occupies bits 63-8k:56-8k.
- R5: The status word is written in the cycle right after the packet's final data word. In little-endian order its bit 63 is the OR of `in_perr` over the packet's bytes, bit 62 is the OR of `in_start_err`, bits 61:42 are zero, bits 41:33 hold the 9-bit extension and bits 32:0 hold the 33-bit base.
- R6: When `big_endian` is 1, the status word is the little-endian status word with its eight bytes reversed.
- R7: `pkt_len` is sampled on a packet's first byte, and later changes do not affect that packet. A value of 0 acts as 1, and the typical value is 188. A final word that is only partly filled has zeros in its unused byte lanes.
- R8: `ts_req` is high only in the cycle in which a packet's first byte is taken. `ts_base` and `ts_ext` are sampled in that cycle, and those values appear in the packet's status word.
- R9: If `fifo_full` is 1 on an edge where a word is due, that word is not written, `overflow` becomes 1 and stays 1, and no further words of that packet, including its status word, are written. The next packet is handled normally.
- R10: A synchronous reset (`rst` = 1) clears the byte position, the partial word, any pending status word and `overflow`. After reset `in_ready` is 1 and `fifo_wr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte present on `in_byte` |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_byte | input | 8 | Packet byte |
| in_perr | input | 1 | Data error marker for this byte |
| in_start_err | input | 1 | Packet-start error marker for this byte |
| pkt_len | input | 8 | Packet length in bytes |
| big_endian | input | 1 | Lane order: 0 little-endian, 1 big-endian |
| ts_req | output | 1 | Request to sample the reference counter |
| ts_base | input | 33 | Reference counter base value |
| ts_ext | input | 9 | Reference counter extension value |
| fifo_full | input | 1 | FIFO cannot take a word |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | 64 | FIFO write word |
| overflow | output | 1 | Sticky: a word was dropped |

## Verification
The status write and the completion of a data word can overlap when a packet ends on a word boundary or has a length under eight. In that case the final data word and the status word must go out on consecutive cycles, and the stalled `in_ready` cycle is what stops the next packet from colliding with them. The bench provokes this with packets of length 1, 8 and 16 while it holds `in_valid` high. It judges the result from the capture cycle numbers of the last two writes and from the value of `in_ready` in that one stalled cycle. A second overlap is a full FIFO in the cycle a word is due in the middle of a packet. For that case the bench requires zero writes for the whole packet and then a normal next packet.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 64;
  localparam int LANES   = WORD_W / BYTE_W;
  localparam int LANE_W  = $clog2(LANES);
  localparam int BASE_W  = 33;
  localparam int EXT_W   = 9;
  localparam int RSVD_W  = WORD_W - 2 - BASE_W - EXT_W;

  typedef struct packed {
    logic              perr;
    logic              pst_err;
    logic [RSVD_W-1:0] rsvd;
    logic [EXT_W-1:0]  ext;
    logic [BASE_W-1:0] base;
  } tsp_status_t;

  function automatic logic [WORD_W-1:0] lane_reverse(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < LANES; i++) begin
      r[BYTE_W*i +: BYTE_W] = w[BYTE_W*(LANES-1-i) +: BYTE_W];
    end
    return r;
  endfunction
endpackage

// File: rtl/tsp_pkt_counter.sv
module tsp_pkt_counter
  import tsp_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [LEN_W-1:0]  pkt_len,
  output logic              first,
  output logic              last,
  output logic [LANE_W-1:0] lane
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cur_len;
  logic [LEN_W-1:0] eff_len;

  always_comb begin
    first   = (cnt_q == '0);
    cur_len = first ? pkt_len : len_q;
    eff_len = (cur_len == '0) ? LEN_W'(1) : cur_len;
    last    = (cnt_q == eff_len - LEN_W'(1));
    lane    = cnt_q[LANE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      len_q <= '0;
    end else if (accept) begin
      cnt_q <= last ? '0 : cnt_q + LEN_W'(1);
      if (first) len_q <= pkt_len;
    end
  end

  // R7: a packet end always returns the counter to the first position
  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    accept && last |=> first);

  // R7: the length taken on the first byte is kept for the packet
  p_len_held_r7: assert property (@(posedge clk) disable iff (rst)
    accept && !first |=> $stable(len_q));
endmodule

// File: rtl/tsp_lane_packer.sv
module tsp_lane_packer
  import tsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [LANE_W-1:0] lane,
  input  logic [BYTE_W-1:0] din,
  output logic [WORD_W-1:0] word_le
);
  logic [LANES-1:0][BYTE_W-1:0] acc_q;
  logic [LANES-1:0][BYTE_W-1:0] acc_nxt;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      if (lane == LANE_W'(k))      acc_nxt[k] = din;
      else if (lane == '0)         acc_nxt[k] = '0;
      else                         acc_nxt[k] = acc_q[k];
    end
  end

  assign word_le = acc_nxt;

  always_ff @(posedge clk) begin
    if (rst)         acc_q <= '0;
    else if (accept) acc_q <= acc_nxt;
  end

  // R7: starting a word leaves every higher lane zero for padding
  p_pad_zero_r7: assert property (@(posedge clk) disable iff (rst)
    accept && lane == '0 |=> acc_q[LANES-1:1] == '0);
endmodule

// File: rtl/tsp_status_fmt.sv
module tsp_status_fmt
  import tsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              first,
  input  logic              in_perr,
  input  logic              in_start_err,
  input  logic [BASE_W-1:0] ts_base,
  input  logic [EXT_W-1:0]  ts_ext,
  output tsp_status_t       status
);
  logic [BASE_W-1:0] base_q;
  logic [EXT_W-1:0]  ext_q;
  logic              perr_q;
  logic              pst_q;
  tsp_status_t       nxt;

  always_comb begin
    nxt.perr    = in_perr | (!first & perr_q);
    nxt.pst_err = in_start_err | (!first & pst_q);
    nxt.rsvd    = '0;
    nxt.ext     = first ? ts_ext  : ext_q;
    nxt.base    = first ? ts_base : base_q;
  end

  assign status = nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      ext_q  <= '0;
      perr_q <= 1'b0;
      pst_q  <= 1'b0;
    end else if (accept) begin
      base_q <= nxt.base;
      ext_q  <= nxt.ext;
      perr_q <= nxt.perr;
      pst_q  <= nxt.pst_err;
    end
  end

  // R8: the sampled reference stays put until the next packet begins
  p_ts_held_r8: assert property (@(posedge clk) disable iff (rst)
    !(accept && first) |=> $stable(base_q) && $stable(ext_q));
endmodule

// File: rtl/tsp_fifo_packer.sv
module tsp_fifo_packer
  import tsp_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  input  logic              in_perr,
  input  logic              in_start_err,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic              big_endian,
  output logic              ts_req,
  input  logic [32:0]       ts_base,
  input  logic [8:0]        ts_ext,
  input  logic              fifo_full,
  output logic              fifo_wr_en,
  output logic [63:0]       fifo_wr_data,
  output logic              overflow
);
  logic              accept;
  logic              first;
  logic              last;
  logic [LANE_W-1:0] lane;
  logic              word_end;
  logic              drop_q;
  logic              drop_now;
  logic              stat_pend_q;
  logic [WORD_W-1:0] stat_q;
  logic [WORD_W-1:0] word_le;
  tsp_status_t       status;

  assign in_ready = !stat_pend_q;
  assign accept   = in_valid && in_ready;
  assign ts_req   = accept && first;
  assign word_end = (lane == LANE_W'(LANES-1)) || last;
  assign drop_now = drop_q || fifo_full;

  tsp_pkt_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst(rst), .accept(accept), .pkt_len(pkt_len),
    .first(first), .last(last), .lane(lane)
  );

  tsp_lane_packer u_pack (
    .clk(clk), .rst(rst), .accept(accept), .lane(lane),
    .din(in_byte), .word_le(word_le)
  );

  tsp_status_fmt u_stat (
    .clk(clk), .rst(rst), .accept(accept), .first(first),
    .in_perr(in_perr), .in_start_err(in_start_err),
    .ts_base(ts_base), .ts_ext(ts_ext), .status(status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_wr_en   <= 1'b0;
      fifo_wr_data <= '0;
      stat_pend_q  <= 1'b0;
      stat_q       <= '0;
      drop_q       <= 1'b0;
      overflow     <= 1'b0;
    end else begin
      fifo_wr_en <= 1'b0;
      if (stat_pend_q) begin
        stat_pend_q <= 1'b0;
        if (fifo_full) begin
          overflow <= 1'b1;
        end else begin
          fifo_wr_en   <= 1'b1;
          fifo_wr_data <= stat_q;
        end
      end else if (accept && word_end) begin
        if (drop_now) begin
          if (fifo_full) overflow <= 1'b1;
        end else begin
          fifo_wr_en   <= 1'b1;
          fifo_wr_data <= big_endian ? lane_reverse(word_le) : word_le;
        end
        if (last) begin
          drop_q      <= 1'b0;
          stat_pend_q <= !drop_now;
          stat_q      <= big_endian ? lane_reverse(status) : status;
        end else begin
          drop_q <= drop_now;
        end
      end
    end
  end

  // R1: a completed, undropped packet stalls the byte input for one cycle
  p_stall_r1: assert property (@(posedge clk) disable iff (rst)
    accept && last && !drop_q && !fifo_full |=> !in_ready);

  // R5: the status slot comes two cycles after the final byte
  p_status_follows_r5: assert property (@(posedge clk) disable iff (rst)
    accept && last && !drop_q && !fifo_full |=> ##1 (fifo_wr_en || overflow));

  // R8: the sampling request never lasts two cycles
  p_ts_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    ts_req |=> !ts_req);

  // R9: no write is issued against a full FIFO
  p_no_write_full_r9: assert property (@(posedge clk) disable iff (rst)
    fifo_wr_en |-> !$past(fifo_full));

  // R9: overflow is sticky until reset
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
endmodule

// File: tb/test_tsp_fifo_packer.sv
module test_tsp_fifo_packer;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  localparam int V_LEN  [NVEC] = '{188, 8, 13, 1, 16, 0};
  localparam bit V_BE   [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam int V_PERR [NVEC] = '{100, 255, 12, 0, 255, 255};
  localparam bit V_PST  [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = '0;
  logic        in_perr = 1'b0;
  logic        in_start_err = 1'b0;
  logic [7:0]  pkt_len = 8'd188;
  logic        big_endian = 1'b0;
  logic        ts_req;
  logic [32:0] ts_base = '0;
  logic [8:0]  ts_ext = '0;
  logic        fifo_full = 1'b0;
  logic        fifo_wr_en;
  logic [63:0] fifo_wr_data;
  logic        overflow;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int ncap    = 0;
  logic [63:0] cap [64];
  int          cap_cyc [64];

  tsp_fifo_packer i_tsp_fifo_packer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_perr(in_perr), .in_start_err(in_start_err),
    .pkt_len(pkt_len), .big_endian(big_endian), .ts_req(ts_req),
    .ts_base(ts_base), .ts_ext(ts_ext), .fifo_full(fifo_full),
    .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data), .overflow(overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (fifo_wr_en && ncap < 64) begin
      cap[ncap]     = fifo_wr_data;
      cap_cyc[ncap] = cyc;
      ncap          = ncap + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k, input int i);
    return 8'((i * 37 + k * 11 + 5) & 255);
  endfunction

  function automatic logic [63:0] rev8(input logic [63:0] w);
    logic [63:0] r;
    for (int j = 0; j < 8; j++) r[63-8*j -: 8] = w[8*j +: 8];
    return r;
  endfunction

  function automatic logic [63:0] exp_word(input int k, input int eff, input int w,
                                           input bit be);
    logic [63:0] r = '0;
    for (int j = 0; j < 8; j++) begin
      if (8*w + j < eff) r[8*j +: 8] = pat(k, 8*w + j);
    end
    return be ? rev8(r) : r;
  endfunction

  function automatic logic [32:0] base_of(input int k);
    return 33'h1_8000_0001 ^ 33'(k * 32'h0123_4567);
  endfunction

  function automatic logic [8:0] ext_of(input int k);
    return 9'((k * 53 + 17) & 511);
  endfunction

  // Sends one packet; full_at is the byte index during which fifo_full is high.
  task automatic send_pkt(input int k, input int len, input bit be, input int perr_idx,
                          input bit pst, input int full_at, input bit expect_stall);
    int eff = (len == 0) ? 1 : len;
    big_endian = be;
    ncap = 0;
    for (int i = 0; i < eff; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid     = 1'b1;
      in_byte      = pat(k, i);
      in_perr      = (i == perr_idx);
      in_start_err = pst && (i == 0);
      pkt_len      = (i == 0) ? 8'(len) : 8'd3;
      ts_base      = (i == 0) ? base_of(k) : '0;
      ts_ext       = (i == 0) ? ext_of(k)  : '0;
      fifo_full    = (i == full_at);
      #1;
      if (i < 2) chk(ts_req == (i == 0), "R8 ts_req pulse", 64'(ts_req), 64'(i == 0));
    end
    @(negedge clk);
    in_valid  = 1'b0;
    in_perr   = 1'b0;
    fifo_full = 1'b0;
    if (expect_stall) begin
      chk(in_ready == 1'b0, "R1 stall after last byte", 64'(in_ready), 64'd0);
      @(negedge clk);
      chk(in_ready == 1'b1, "R1 ready again", 64'(in_ready), 64'd1);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic verify_pkt(input int k, input int len, input bit be, input int perr_idx,
                            input bit pst);
    int eff = (len == 0) ? 1 : len;
    int nw  = (eff + 7) / 8;
    logic [63:0] st;
    chk(ncap == nw + 1, "R2 write count", 64'(ncap), 64'(nw + 1));
    if (ncap == nw + 1) begin
      for (int w = 0; w < nw; w++) begin
        chk(cap[w] == exp_word(k, eff, w, be), be ? "R4 R7 data word BE" : "R3 R7 data word LE",
            cap[w], exp_word(k, eff, w, be));
      end
      st = {(perr_idx < eff), pst, 20'd0, ext_of(k), base_of(k)};
      if (be) st = rev8(st);
      chk(cap[nw] == st, be ? "R6 R8 status BE" : "R5 R8 status LE", cap[nw], st);
      if (nw > 0)
        chk(cap_cyc[nw] == cap_cyc[nw-1] + 1, "R5 status adjacent",
            64'(cap_cyc[nw]), 64'(cap_cyc[nw-1] + 1));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && fifo_wr_en == 1'b0 && overflow == 1'b0, "R10 reset state",
        {61'd0, in_ready, fifo_wr_en, overflow}, 64'h4);
    rst = 1'b0;

    for (int k = 0; k < NVEC; k++) begin
      send_pkt(k, V_LEN[k], V_BE[k], V_PERR[k], V_PST[k], -1, 1'b1);
      verify_pkt(k, V_LEN[k], V_BE[k], V_PERR[k], V_PST[k]);
    end
    chk(overflow == 1'b0, "R9 no overflow without full", 64'(overflow), 64'd0);

    // R9: full at the first word due: whole packet dropped, status included
    send_pkt(7, 16, 1'b0, 3, 1'b0, 7, 1'b0);
    chk(ncap == 0, "R9 dropped packet writes", 64'(ncap), 64'd0);
    chk(overflow == 1'b1, "R9 overflow set", 64'(overflow), 64'd1);
    chk(in_ready == 1'b1, "R1 no stall on dropped packet", 64'(in_ready), 64'd1);

    // R9: next packet normal, overflow sticky
    send_pkt(8, 8, 1'b1, 255, 1'b0, -1, 1'b1);
    verify_pkt(8, 8, 1'b1, 255, 1'b0);
    chk(overflow == 1'b1, "R9 overflow sticky", 64'(overflow), 64'd1);

    // R10: partial packet then reset clears position and partial word
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = 8'hEE;
      pkt_len  = 8'd20;
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst      = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(overflow == 1'b0, "R10 overflow cleared", 64'(overflow), 64'd0);
    send_pkt(9, 8, 1'b0, 255, 1'b1, -1, 1'b1);
    verify_pkt(9, 8, 1'b0, 255, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule